// File: doc/BRIEF.md
# Edge interrupt controller

This block turns transitions on external pins into interrupt requests, one request per line. Each line picks its pin from one of several ports through a per-line source selector. The chosen pin is brought into the clock domain through a two-stage synchronizer. An edge detector then compares it with its previous value. Two separate enable words arm detection of low-to-high and high-to-low transitions. A detected, armed edge latches into a pending word.

A line's request is its pending bit gated by its mask bit. The request stays high until software clears the pending bit by writing a one to it. An interrupt handler that does not clear the bit is therefore entered again at once. All configuration and the pending word sit behind a single-cycle register interface. Writes take effect on the clock edge. Reads return the addressed word combinationally from the address.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every register reads zero and every request output is low.
- R2: With a line's fall enable set, a high-to-low change on its selected pin sets its pending bit on the third rising clock edge after the change. Without an armed edge, a pending bit never becomes set.
- R3: With a line's rise enable set, a low-to-high change on its selected pin sets its pending bit with the same latency as R2.
- R4: With both enables set, a line detects both transitions. With neither set, it detects none.
- R5: Request output bit i equals pending bit i AND mask bit i. A line whose mask bit is zero never asserts its request, even while pending.
- R6: Writing the pending word (byte offset 0x14) clears every bit written as one and leaves bits written as zero unchanged. Such a write never sets a bit.
- R7: When an armed edge and a clearing write reach the same line on the same clock edge, the pending bit stays set.
- R8: Without a clearing write, a set pending bit and its unmasked request stay asserted indefinitely.
- R9: Line i is driven by pin i of the port named by its 4-bit select field. Port p pin i is input bit p*16+i, and value 0 selects port 0. A select value of at least the number of ports feeds a constant low.
- R10: The register offsets are: mask at 0x00, rise enables at 0x08, fall enables at 0x0C and pending at 0x14. Bit i of each of these words belongs to line i, and bits 31:16 read zero. Select fields for lines 0-7 are at 0x20 and those for lines 8-15 are at 0x24, with line i in bits 4*(i%8)+3 down to 4*(i%8). Any other address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| port_pins | input | 64 | External pins, port p pin i at bit p*16+i |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 16 | Request per line |

## Verification
The assertions assume the following: a write is one cycle long with address and data stable around the edge; pins may change at any time, since they are synchronized first; and reset is held long enough to flush the synchronizer. The stimulus keeps every pin low during reset, so no edge appears when reset is released. It changes pins and bus signals only just after a rising edge, so every detection latency is counted from a known edge. It changes a select field only while the old and new sources are both low, so no selector switch creates an edge.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned OFS_MASK     = 'h00;
  localparam int unsigned OFS_RISE     = 'h08;
  localparam int unsigned OFS_FALL     = 'h0C;
  localparam int unsigned OFS_PEND     = 'h14;
  localparam int unsigned OFS_SEL_BASE = 'h20;
  localparam int unsigned SYNC_STAGES  = 2;
endpackage

// File: rtl/extint_src_mux.sv
module extint_src_mux #(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_PORTS*NUM_LINES-1:0] pins,
  input  logic [NUM_LINES*SEL_W-1:0]     sel,
  output logic [NUM_LINES-1:0]           line_in
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [SEL_W-1:0] s;
    assign s = sel[i*SEL_W +: SEL_W];
    always_comb begin
      line_in[i] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (s == SEL_W'(p)) line_in[i] = pins[p*NUM_LINES + i];
      end
    end
  end
endmodule

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_edge.sv
module extint_edge #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] level,
  input  logic [NUM_LINES-1:0] rise_en,
  input  logic [NUM_LINES-1:0] fall_en,
  output logic [NUM_LINES-1:0] hit
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] went_up;
  logic [NUM_LINES-1:0] went_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign went_up   = level & ~prev_q;
  assign went_down = ~level & prev_q;
  assign hit       = (went_up & rise_en) | (went_down & fall_en);
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_LINES-1:0]       hit,
  output logic [NUM_LINES-1:0]       mask_q,
  output logic [NUM_LINES-1:0]       rise_q,
  output logic [NUM_LINES-1:0]       fall_q,
  output logic [NUM_LINES-1:0]       pend_q,
  output logic [NUM_LINES*SEL_W-1:0] sel_q
);
  localparam int SEL_BITS  = NUM_LINES * SEL_W;
  localparam int SEL_WORDS = (SEL_BITS + DATA_W - 1) / DATA_W;

  logic [SEL_WORDS*DATA_W-1:0] sel_all;
  logic                        wr_mask, wr_rise, wr_fall, wr_pend;
  logic [NUM_LINES-1:0]        clr_bits;

  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
  assign wr_rise = bus_wr && (bus_addr == ADDR_W'(OFS_RISE));
  assign wr_fall = bus_wr && (bus_addr == ADDR_W'(OFS_FALL));
  assign wr_pend = bus_wr && (bus_addr == ADDR_W'(OFS_PEND));

  assign clr_bits = wr_pend ? bus_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[NUM_LINES-1:0];
      if (wr_rise) rise_q <= bus_wdata[NUM_LINES-1:0];
      if (wr_fall) fall_q <= bus_wdata[NUM_LINES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_all <= '0;
    end else begin
      for (int w = 0; w < SEL_WORDS; w++) begin
        if (bus_wr && bus_addr == ADDR_W'(OFS_SEL_BASE + 4*w))
          sel_all[w*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  // a fresh edge outranks a clear arriving on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_bits) | hit;
  end

  assign sel_q = sel_all[SEL_BITS-1:0];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata = DATA_W'(mask_q);
    if (bus_addr == ADDR_W'(OFS_RISE)) bus_rdata = DATA_W'(rise_q);
    if (bus_addr == ADDR_W'(OFS_FALL)) bus_rdata = DATA_W'(fall_q);
    if (bus_addr == ADDR_W'(OFS_PEND)) bus_rdata = DATA_W'(pend_q);
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (bus_addr == ADDR_W'(OFS_SEL_BASE + 4*w))
        bus_rdata = sel_all[w*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_LINES-1:0]           irq
);
  logic [NUM_LINES*SEL_W-1:0] sel_q;
  logic [NUM_LINES-1:0]       line_raw;
  logic [NUM_LINES-1:0]       line_sync;
  logic [NUM_LINES-1:0]       mask_q, rise_q, fall_q, pend_q;
  logic [NUM_LINES-1:0]       edge_hit;

  extint_src_mux #(
    .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)
  ) u_mux (
    .pins(port_pins), .sel(sel_q), .line_in(line_raw)
  );

  extint_sync #(
    .WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_raw), .q(line_sync)
  );

  extint_edge #(
    .NUM_LINES(NUM_LINES)
  ) u_edge (
    .clk(clk), .rst_n(rst_n), .level(line_sync),
    .rise_en(rise_q), .fall_en(fall_q), .hit(edge_hit)
  );

  extint_regs #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(edge_hit),
    .mask_q(mask_q), .rise_q(rise_q), .fall_q(fall_q), .pend_q(pend_q),
    .sel_q(sel_q)
  );

  assign irq = pend_q & mask_q;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
  import extint_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] irq
);
  logic wr_pend;
  assign wr_pend = bus_wr && (bus_addr == ADDR_W'(OFS_PEND));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~mask_q) == '0));

  p_only_armed_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(edge_hit)) == '0));

  p_clear_by_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(edge_hit)) == '0));

  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));

  p_pending_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind extint_ctrl extint_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .edge_hit(edge_hit), .pend_q(pend_q),
  .mask_q(mask_q), .irq(irq)
);

// File: tb/extint_ctrl_bench.sv
`timescale 1ns/1ps
module extint_ctrl_bench;
  localparam int L  = 16;
  localparam int P  = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [P*L-1:0] pins = '0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [L-1:0]  irq;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  probe = 1'b0;
  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 1'b0;

  always #10 clk = ~clk;

  extint_ctrl u_extint_ctrl (
    .clk(clk), .rst_n(rst_n), .port_pins(pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  // monitor: compares against the scoreboard away from the active edge
  always @(negedge clk) begin
    if (probe) begin
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty on probe");
      end else begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {16'b0, irq} : bus_rdata;
        vectors++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_n(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    tick();
    bus_wr    = 1'b0;
  endtask

  task automatic exp_rd(logic [7:0] a, logic [31:0] e, string tag);
    bus_addr = a;
    q.push_back('{1'b0, e, tag});
    probe = 1'b1;
    tick();
    probe = 1'b0;
  endtask

  task automatic exp_irq(logic [15:0] e, string tag);
    q.push_back('{1'b1, {16'b0, e}, tag});
    probe = 1'b1;
    tick();
    probe = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    exp_rd(8'h00, 32'h0, "R1 mask reset");
    exp_rd(8'h08, 32'h0, "R1 rise reset");
    exp_rd(8'h0C, 32'h0, "R1 fall reset");
    exp_rd(8'h14, 32'h0, "R1 pend reset");
    exp_rd(8'h20, 32'h0, "R1 sel0 reset");
    exp_rd(8'h24, 32'h0, "R1 sel1 reset");
    exp_irq(16'h0, "R1 irq reset");

    // R10 configuration and readback
    wr_reg(8'h00, 32'hFFFF_0029);
    wr_reg(8'h08, 32'h0000_000C);
    wr_reg(8'h0C, 32'h0000_0029);
    wr_reg(8'h20, 32'h0020_0000);
    wr_reg(8'h04, 32'hFFFF_FFFF);
    exp_rd(8'h00, 32'h0000_0029, "R10 mask upper zero");
    exp_rd(8'h08, 32'h0000_000C, "R10 rise readback");
    exp_rd(8'h0C, 32'h0000_0029, "R10 fall readback");
    exp_rd(8'h20, 32'h0020_0000, "R10 sel0 readback");
    exp_rd(8'h24, 32'h0, "R10 sel1 untouched");
    exp_rd(8'h04, 32'h0, "R10 unmapped reads zero");
    wr_reg(8'h14, 32'h0000_FFFF);
    exp_rd(8'h14, 32'h0, "R6 write never sets");

    // R2 falling edge on line 0
    pins[0] = 1'b1; wait_n(4);
    exp_rd(8'h14, 32'h0, "R2 rise ignored without enable");
    pins[0] = 1'b0; wait_n(2);
    exp_rd(8'h14, 32'h0, "R2 not yet after two edges");
    exp_rd(8'h14, 32'h1, "R2 fall sets pending on third edge");
    exp_irq(16'h0001, "R5 unmasked request");
    wait_n(5);
    exp_irq(16'h0001, "R8 request holds");

    // R6 write one to clear
    wr_reg(8'h14, 32'h0000_FFFE);
    exp_rd(8'h14, 32'h1, "R6 zero bit keeps pending");
    wr_reg(8'h14, 32'h0000_0001);
    exp_rd(8'h14, 32'h0, "R6 one bit clears");
    exp_irq(16'h0, "R6 request drops");

    // R3 / R5 rising edge on masked line 2
    pins[2] = 1'b1; wait_n(3);
    exp_rd(8'h14, 32'h4, "R3 rise sets pending");
    exp_irq(16'h0, "R5 masked line silent");
    wr_reg(8'h14, 32'h4);

    // R4 both edges on line 3, none on line 4
    pins[3] = 1'b1; wait_n(3);
    exp_rd(8'h14, 32'h8, "R4 both: rise");
    exp_irq(16'h0008, "R4 irq on rise");
    wr_reg(8'h14, 32'h8);
    pins[3] = 1'b0; wait_n(3);
    exp_rd(8'h14, 32'h8, "R4 both: fall");
    wr_reg(8'h14, 32'h8);
    pins[4] = 1'b1; wait_n(4);
    pins[4] = 1'b0; wait_n(4);
    exp_rd(8'h14, 32'h0, "R4 no enable no detect");

    // R9 source select: line 5 from port 2
    pins[5] = 1'b1; wait_n(4);
    pins[5] = 1'b0; wait_n(4);
    exp_rd(8'h14, 32'h0, "R9 port0 pin ignored");
    pins[37] = 1'b1; wait_n(4);
    pins[37] = 1'b0; wait_n(3);
    exp_rd(8'h14, 32'h20, "R9 port2 pin drives line5");
    exp_irq(16'h0020, "R9 irq from port2");
    wr_reg(8'h14, 32'h20);
    wr_reg(8'h20, 32'h0070_0000);
    pins[37] = 1'b1; pins[5] = 1'b1; pins[53] = 1'b1; wait_n(4);
    pins[37] = 1'b0; pins[5] = 1'b0; pins[53] = 1'b0; wait_n(4);
    exp_rd(8'h14, 32'h0, "R9 out-of-range select is low");

    // R7 edge and clear on the same clock edge
    pins[0] = 1'b1; wait_n(4);
    pins[3] = 1'b1; wait_n(3);
    exp_rd(8'h14, 32'h8, "R7 setup line3 pending");
    pins[0] = 1'b0;
    tick();
    tick();
    wr_reg(8'h14, 32'h9);
    exp_rd(8'h14, 32'h1, "R7 set wins, other bit cleared");
    wr_reg(8'h14, 32'hFFFF);
    exp_rd(8'h14, 32'h0, "R6 final clear");

    tick();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items", q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule